// File: doc/BRIEF.md
# Blanking-Entry Display Busy Interrupt

This block raises an interrupt flag at the moment an on-screen-display timing generator enters a blanking period. Firmware uses that moment as a safe window for writing display memory without visible artifacts. Blanking entry is found by comparing each blanking input with a registered copy of its previous value. A rising edge marks the entry.

One mode bit selects the rate. In line mode the flag rises once per active display line, when horizontal blanking begins. In field mode it rises once per field, when vertical blanking begins. The mode bit sits in a memory-mapped configuration register, which is written through a simple write port. The flag stays set until firmware pulses a clear strobe. Arbitration against other interrupt sources happens outside this block.

Top module: `osd_blank_irq`

## Requirements
- R1: Reset (active-low `rst_n`) clears the flag and selects line mode. Blanking inputs already high when reset is released do not raise the flag.
- R2: In line mode, a rising edge of `hblank` while `line_active` is 1 and `vblank` is 0 sets `irq_flag` one clock after the edge is sampled.
- R3: In line mode, an `hblank` rising edge while `vblank` is 1 or `line_active` is 0 is ignored, and so is any `vblank` edge.
- R4: In field mode, a rising edge of `vblank` sets `irq_flag` one clock after the edge is sampled, and `hblank` edges are ignored.
- R5: Only entry into blanking sets the flag. A blanking input held high does not set it again after a clear.
- R6: A write with `cfg_we`=1 to address `CFG_ADDR` (default 16'h87FF) loads bit `MODE_BIT` (default 0) of `cfg_wdata` as the mode: 0 selects line mode and 1 selects field mode. Writes to any other address leave the mode unchanged.
- R7: A change of mode does not set the flag by itself. The new mode applies from the next blanking entry onward.
- R8: Once set, `irq_flag` holds until `flag_clr` is 1 at a clock edge, and it reads 0 after that edge.
- R9: When a blanking entry and `flag_clr` occur in the same cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank | input | 1 | Horizontal blanking level |
| vblank | input | 1 | Vertical blanking level |
| line_active | input | 1 | Current line lies inside the active display |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (16) | Configuration write address |
| cfg_wdata | input | DATA_W (8) | Configuration write data |
| flag_clr | input | 1 | Clear strobe for the interrupt flag |
| irq_flag | output | 1 | Display-busy interrupt flag |

## Verification
The set path and the clear path can act in the same cycle. This happens when firmware clears the flag just as the next line enters horizontal blanking. The bench provokes it by driving the `hblank` rising edge and `flag_clr` in the same cycle, with the flag already set. It then expects `irq_flag` to read 1 after that edge. A second collision occurs when a mode write lands while a blanking input is high. The bench judges that case by confirming the flag stays low.

// File: rtl/osd_irq_pkg.sv
package osd_irq_pkg;
    typedef enum logic {
        MODE_LINE  = 1'b0,
        MODE_FIELD = 1'b1
    } irq_mode_e;

    localparam int unsigned NUM_BLANK = 2;
    localparam int unsigned IDX_H     = 0;
    localparam int unsigned IDX_V     = 1;
endpackage

// File: rtl/osd_blank_edge.sv
module osd_blank_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d.prev = lvl;
    end

    // Reset to "in blanking" so a level already high after reset is no entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: '1};
        else        st_q <= st_d;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign rise[i] = lvl[i] & ~st_q.prev[i];

            AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
                rise[i] |=> !rise[i]);  // R5
        end
    endgenerate
endmodule

// File: rtl/osd_mode_reg.sv
module osd_mode_reg
    import osd_irq_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 16,
    parameter int unsigned      DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h87FF,
    parameter int unsigned      MODE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output irq_mode_e         mode
);
    typedef struct packed {
        irq_mode_e mode;
    } state_t;

    state_t st_d, st_q;
    logic   hit;
    logic   unused_wdata;

    assign hit          = we && (addr == CFG_ADDR);
    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (hit) st_d.mode = irq_mode_e'(wdata[MODE_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_LINE};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;

    AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(mode));  // R6
endmodule

// File: rtl/osd_busy_flag.sv
module osd_busy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d.flag = set | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);  // R9
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);  // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);  // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set) |=> !flag);  // R7
endmodule

// File: rtl/osd_blank_irq.sv
module osd_blank_irq
    import osd_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h87FF,
    parameter int unsigned       MODE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              line_active,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              flag_clr,
    output logic              irq_flag
);
    logic [NUM_BLANK-1:0] lvl;
    logic [NUM_BLANK-1:0] rise;
    irq_mode_e            mode;
    logic                 set_line;
    logic                 set_field;
    logic                 set_flag;

    assign lvl[IDX_H] = hblank;
    assign lvl[IDX_V] = vblank;

    osd_blank_edge #(.WIDTH(NUM_BLANK)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    osd_mode_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_ADDR(CFG_ADDR),
        .MODE_BIT(MODE_BIT)
    ) u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .mode (mode)
    );

    // Line mode: horizontal entry only on active lines outside vertical blanking.
    assign set_line  = (mode == MODE_LINE) && rise[IDX_H] && line_active && !vblank;
    assign set_field = (mode == MODE_FIELD) && rise[IDX_V];
    assign set_flag  = set_line | set_field;

    osd_busy_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_flag),
        .clr  (flag_clr),
        .flag (irq_flag)
    );

    AST_LINE_VBLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_LINE) && vblank && !irq_flag) |=> !irq_flag);  // R3
    AST_FIELD_NEEDS_V: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FIELD) && !vblank && !irq_flag) |=> !irq_flag);  // R4
endmodule

// File: tb/osd_blank_irq_test.sv
module osd_blank_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hblank = 1'b1;
    logic        vblank = 1'b1;
    logic        line_active = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        irq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    osd_blank_irq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hblank     (hblank),
        .vblank     (vblank),
        .line_active(line_active),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .flag_clr   (flag_clr),
        .irq_flag   (irq_flag)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic exp);
        checks++;
        if (irq_flag !== exp) begin
            errors++;
            $display("FAIL %s irq_flag actual=%b expected=%b", req, irq_flag, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    task automatic write_cfg(logic [15:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; tick();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        tick(2); rst_n = 1'b1; tick(3);
        chk("R1 no flag after reset with blanking high", 1'b0);
        hblank = 1'b0; vblank = 1'b0; line_active = 1'b1; tick();
        hblank = 1'b1; tick();
        chk("R1 reset selects line mode", 1'b1);
        clear_flag(); hblank = 1'b0; tick();
    endtask

    task automatic t_line_basic();
        hblank = 1'b1; tick();
        chk("R2 hblank entry sets flag", 1'b1);
        tick(4);
        chk("R8 flag holds without clear", 1'b1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R8 clear drops flag", 1'b0);
        tick(3);
        chk("R5 held hblank does not retrigger", 1'b0);
        hblank = 1'b0; tick();
    endtask

    task automatic t_line_ignored();
        line_active = 1'b0; hblank = 1'b1; tick(2);
        chk("R3 inactive line ignored", 1'b0);
        hblank = 1'b0; line_active = 1'b1; vblank = 1'b1; tick(2);
        chk("R3 vblank edge ignored in line mode", 1'b0);
        hblank = 1'b1; tick(2);
        chk("R3 hblank during vblank ignored", 1'b0);
        hblank = 1'b0; vblank = 1'b0; tick();
    endtask

    task automatic t_cfg();
        write_cfg(16'h87FE, 8'h01);
        vblank = 1'b1; tick(2);
        chk("R6 other address leaves line mode", 1'b0);
        hblank = 1'b1; vblank = 1'b0; tick();
        chk("R6 still line mode", 1'b1);
        clear_flag(); hblank = 1'b0; tick();
        write_cfg(16'h87FF, 8'h01);
        tick();
        chk("R7 mode write does not set flag", 1'b0);
        hblank = 1'b1; tick(2);
        chk("R4 hblank ignored in field mode", 1'b0);
        hblank = 1'b0; vblank = 1'b1; tick();
        chk("R4 vblank entry sets flag", 1'b1);
        clear_flag(); tick(2);
        chk("R5 held vblank does not retrigger", 1'b0);
        write_cfg(16'h87FF, 8'h00);
        tick();
        chk("R7 switch to line mode in vblank sets nothing", 1'b0);
        vblank = 1'b0; tick();
        hblank = 1'b1; tick();
        chk("R6 bit 0 cleared selects line mode", 1'b1);
        hblank = 1'b0; tick();
    endtask

    task automatic t_collision();
        chk("R9 flag set before collision", 1'b1);
        hblank = 1'b1; flag_clr = 1'b1; tick();
        flag_clr = 1'b0;
        chk("R9 entry wins over same-cycle clear", 1'b1);
        clear_flag();
        chk("R8 later clear drops flag", 1'b0);
        hblank = 1'b0; tick();
    endtask

    initial begin
        t_reset();
        t_line_basic();
        t_line_ignored();
        t_cfg();
        t_collision();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule